// File: doc/BRIEF.md
# Unary Half-Scaled Stream Adder

This block adds two 6-bit non-negative integers by turning each into a unary stream whose ones are packed at the front, then merging the two streams through a 2:1 multiplexer. A select stream made inside the block drives the multiplexer, one bit per cycle. The output stream therefore carries roughly half of each operand's ones. Counting the ones in the output and doubling the count gives the sum.

The select stream comes from one of two sources, chosen when the run starts. One is a free-running position counter that selects operand A on even positions. The other is a maximal-length 6-bit LFSR. A double-length mode runs the stream for twice as many cycles. In that mode every unary position is visited once for each operand, so the ones count is exactly the sum and no doubling is applied.

A one-cycle start strobe launches a run. The block shows the stream bit on every cycle of the run, and raises a done pulse once the last bit has been counted. The count and the sum then hold until the next accepted start.

Top module: `usadd_top`

## Requirements
- R1: After reset, `done`, `bit_vld`, `bit_out`, `ones_cnt` and `sum_out` are all 0.
- R2: At stream position p, an operand's unary bit is 1 exactly when p is less than the operand's value (thermometer form, ones first).
- R3: On every cycle of a run, `bit_out` is operand A's unary bit when select is 1 and operand B's bit when select is 0. Where both bits are 1, `bit_out` is 1. `ones_cnt` grows by at most 1 per cycle.
- R4: With `use_lfsr`=0 in normal mode, select is 1 at even positions (0, 2, 4, ...) and 0 at odd ones. Under this rule 35+21 gives 56 and 30+21 gives 50.
- R5: With `use_lfsr`=1 in normal mode, a 6-bit LFSR is loaded with 6'b000001 at start. It steps each cycle as next = {s[4:0], s[5]^s[4]}, and select is s[0]. The state is never all-zero.
- R6: Normal mode (`dbl_len`=0) runs for 63 cycles at positions 0..62, and `sum_out` is twice `ones_cnt`.
- R7: Double mode (`dbl_len`=1) runs for 126 cycles. Cycle i uses position i/2, and select is 1 when i is even. `sum_out` equals `ones_cnt`, which equals A+B exactly (15+8 gives 23, 63+63 gives 126). `use_lfsr` has no effect in this mode.
- R8: `done` is high for exactly one cycle, on the cycle after the last stream bit has been counted. `ones_cnt` and `sum_out` then stay constant until the next accepted start.
- R9: A `start` that arrives while a run is in progress is ignored. The run's length and result are unchanged.
- R10: Operands 0 and 0 give a sum of 0 in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch strobe; latches operands and modes when idle |
| opa | input | 6 | Operand A, binary |
| opb | input | 6 | Operand B, binary |
| use_lfsr | input | 1 | 1 selects the LFSR as the select source, 0 the position counter |
| dbl_len | input | 1 | 1 selects the exact double-length mode |
| bit_out | output | 1 | Multiplexed output stream bit |
| bit_vld | output | 1 | High on every cycle of a run |
| ones_cnt | output | 7 | Ones counted in the output stream |
| sum_out | output | 7 | Reconstructed sum |
| done | output | 1 | One-cycle completion pulse |

## Verification
The operand pairs cover three cases. Pairs with equal values give an empty single-operand region. Pairs whose single-operand span is even, such as 35 and 21, come out exact, while an odd span, such as 30 and 21, shows the -1 error under the counter source. Each pair is run under the counter source, under the LFSR, and in double mode, so errors that depend on the select source can be told apart from the exact double-length count. The stream is compared bit by bit against an independent model of the select rules, which separates a wrong multiplexer polarity from a wrong select sequence. Directed runs cover zero operands, the 63+63 maximum, a start during a run, and the holding of the result after done.

// File: rtl/usadd_pkg.sv
package usadd_pkg;

  typedef enum logic {
    SRC_RAMP = 1'b0,
    SRC_LFSR = 1'b1
  } sel_src_e;

  // Feedback tap mask for a Fibonacci shift register of width w (shift left).
  function automatic logic [7:0] lfsr_taps(input int w);
    case (w)
      3:       lfsr_taps = 8'b0000_0110;
      4:       lfsr_taps = 8'b0000_1100;
      5:       lfsr_taps = 8'b0001_0100;
      6:       lfsr_taps = 8'b0011_0000;
      7:       lfsr_taps = 8'b0110_0000;
      default: lfsr_taps = 8'b1011_1000;
    endcase
  endfunction

endpackage

// File: rtl/usadd_therm.sv
module usadd_therm #(
  parameter int W = 6
) (
  input  logic [W-1:0] pos,
  input  logic [W-1:0] value,
  output logic         ubit
);
  // Thermometer conversion: ones while the position is below the value.
  always_comb begin
    ubit = (pos < value);
  end
endmodule

// File: rtl/usadd_selgen.sv
module usadd_selgen
  import usadd_pkg::*;
#(
  parameter int W  = 6,
  parameter int CW = W + 1,
  parameter logic [W-1:0] SEED = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          adv,
  input  sel_src_e      src,
  input  logic          dbl,
  input  logic [CW-1:0] cyc,
  output logic          sel
);
  localparam logic [W-1:0] TAPS = W'(lfsr_taps(W));

  logic [W-1:0] lfsr_q, lfsr_d;
  logic         fb;

  always_comb begin
    fb     = ^(lfsr_q & TAPS);
    lfsr_d = lfsr_q;
    if (load)     lfsr_d = SEED;
    else if (adv) lfsr_d = {lfsr_q[W-2:0], fb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr_q <= SEED;
    else        lfsr_q <= lfsr_d;
  end

  // Even cycles favour operand A; the LFSR only applies in normal length.
  always_comb begin
    if (src == SRC_LFSR && !dbl) sel = lfsr_q[0];
    else                         sel = ~cyc[0];
  end

  p_lfsr_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);

  p_lfsr_seeded_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (lfsr_q == SEED));
endmodule

// File: rtl/usadd_acc.sv
module usadd_acc #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic          bit_in,
  output logic [CW-1:0] cnt
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)             cnt_d = '0;
    else if (en && bit_in) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/usadd_top.sv
module usadd_top
  import usadd_pkg::*;
#(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         use_lfsr,
  input  logic         dbl_len,
  output logic         bit_out,
  output logic         bit_vld,
  output logic [W:0]   ones_cnt,
  output logic [W:0]   sum_out,
  output logic         done
);
  localparam int CW = W + 1;
  localparam int L  = (1 << W) - 1;
  localparam logic [CW-1:0] LAST_N = CW'(L - 1);
  localparam logic [CW-1:0] LAST_D = CW'(2 * L - 1);

  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic          dbl_q, dbl_d;
  sel_src_e      src_q, src_d;
  logic [W-1:0]  a_q, a_d, b_q, b_d;
  logic [CW-1:0] cyc_q, cyc_d;
  logic          accept, last;
  logic [W-1:0]  pos;
  logic          sel;
  logic [1:0]    ubits;
  logic [CW-1:0] ones;

  always_comb begin
    accept = start && !busy_q;
    last   = busy_q && (cyc_q == (dbl_q ? LAST_D : LAST_N));
    pos    = dbl_q ? cyc_q[CW-1:1] : cyc_q[W-1:0];
  end

  always_comb begin
    busy_d = busy_q;
    cyc_d  = cyc_q;
    dbl_d  = dbl_q;
    src_d  = src_q;
    a_d    = a_q;
    b_d    = b_q;
    done_d = last;
    if (accept) begin
      busy_d = 1'b1;
      cyc_d  = '0;
      dbl_d  = dbl_len;
      src_d  = use_lfsr ? SRC_LFSR : SRC_RAMP;
      a_d    = opa;
      b_d    = opb;
    end else if (busy_q) begin
      cyc_d = cyc_q + 1'b1;
      if (last) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      dbl_q  <= 1'b0;
      src_q  <= SRC_RAMP;
      a_q    <= '0;
      b_q    <= '0;
      cyc_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      dbl_q  <= dbl_d;
      src_q  <= src_d;
      a_q    <= a_d;
      b_q    <= b_d;
      cyc_q  <= cyc_d;
    end
  end

  usadd_selgen #(.W(W), .CW(CW)) u_sel (
    .clk  (clk),
    .rst_n(rst_n),
    .load (accept),
    .adv  (busy_q),
    .src  (src_q),
    .dbl  (dbl_q),
    .cyc  (cyc_q),
    .sel  (sel)
  );

  for (genvar k = 0; k < 2; k++) begin : g_therm
    usadd_therm #(.W(W)) u_th (
      .pos  (pos),
      .value((k == 0) ? a_q : b_q),
      .ubit (ubits[k])
    );
  end

  always_comb begin
    bit_out = busy_q && (sel ? ubits[0] : ubits[1]);
    bit_vld = busy_q;
  end

  usadd_acc #(.CW(CW)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept),
    .en    (busy_q),
    .bit_in(bit_out),
    .cnt   (ones)
  );

  always_comb begin
    ones_cnt = ones;
    sum_out  = dbl_q ? ones : {ones[CW-2:0], 1'b0};
    done     = done_q;
  end

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  p_hold_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !start) |=> ($stable(ones_cnt) && $stable(sum_out)));

  p_both_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && ubits[0] && ubits[1]) |-> bit_out);

  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start && !last) |=> (busy_q && cyc_q == $past(cyc_q) + 1'b1));

  p_normal_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !dbl_q) |-> (cyc_q <= LAST_N));
endmodule

// File: tb/sim_usadd_top.sv
module sim_usadd_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [5:0] opa = '0, opb = '0;
  logic       use_lfsr = 1'b0, dbl_len = 1'b0;
  logic       bit_out, bit_vld, done;
  logic [6:0] ones_cnt, sum_out;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  usadd_top u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .opa(opa), .opb(opb),
    .use_lfsr(use_lfsr), .dbl_len(dbl_len), .bit_out(bit_out),
    .bit_vld(bit_vld), .ones_cnt(ones_cnt), .sum_out(sum_out), .done(done)
  );

  // {a, b, use_lfsr, dbl_len}
  localparam logic [13:0] VEC [10] = '{
    {6'd35, 6'd21, 1'b0, 1'b0},
    {6'd30, 6'd21, 1'b0, 1'b0},
    {6'd35, 6'd21, 1'b1, 1'b0},
    {6'd30, 6'd21, 1'b1, 1'b0},
    {6'd17, 6'd17, 1'b0, 1'b0},
    {6'd9,  6'd40, 1'b1, 1'b0},
    {6'd15, 6'd8,  1'b0, 1'b1},
    {6'd15, 6'd8,  1'b1, 1'b1},
    {6'd1,  6'd62, 1'b0, 1'b1},
    {6'd63, 6'd0,  1'b1, 1'b0}
  };

  // Expected stream bit at cycle i of a run (R2, R4, R5, R7).
  function automatic bit model_bit(int a, int b, bit l, bit d, int i);
    logic [5:0] s = 6'b000001;
    int  p = d ? i / 2 : i;
    bit  sel;
    for (int k = 0; k < i; k++) s = {s[4:0], s[5] ^ s[4]};
    sel = (l && !d) ? s[0] : (i % 2 == 0);
    return sel ? (p < a) : (p < b);
  endfunction

  function automatic int model_ones(int a, int b, bit l, bit d);
    int n = d ? 126 : 63;
    int o = 0;
    for (int i = 0; i < n; i++) o += int'(model_bit(a, b, l, d, i));
    return o;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Runs one addition; optional stray start at stream cycle 10 (R9).
  task automatic run(int a, int b, bit l, bit d, bit stray,
                     output int got_sum, output int got_ones,
                     output int ncyc, output int nmis, output int done_w);
    int guard = 0;
    ncyc = 0; nmis = 0; done_w = 0;
    @(negedge clk);
    opa = 6'(a); opb = 6'(b); use_lfsr = l; dbl_len = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && guard < 400) begin
      if (bit_vld) begin
        if (bit_out !== model_bit(a, b, l, d, ncyc)) nmis++;
        ncyc++;
      end
      if (stray && ncyc == 10) begin
        start = 1'b1; opa = 6'd5; opb = 6'd5; dbl_len = ~d;
      end else begin
        start = 1'b0;
      end
      guard++;
      @(negedge clk);
    end
    start = 1'b0;
    got_sum = int'(sum_out); got_ones = int'(ones_cnt);
    @(negedge clk);
    done_w = int'(done);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int s, o, n, m, dw, eo, es;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(done === 1'b0 && bit_vld === 1'b0 && bit_out === 1'b0,
          "R1 flags", int'({done, bit_vld, bit_out}), 0);
    check(ones_cnt === 7'd0 && sum_out === 7'd0, "R1 counts",
          int'(sum_out), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < 10; v++) begin
      int a = int'(VEC[v][13:8]);
      int b = int'(VEC[v][7:2]);
      bit l = VEC[v][1];
      bit d = VEC[v][0];
      run(a, b, l, d, 1'b0, s, o, n, m, dw);
      eo = model_ones(a, b, l, d);
      es = d ? eo : 2 * eo;
      check(m == 0, "R2 R3 R4 R5 stream bits", m, 0);
      check(o == eo, "R3 ones count", o, eo);
      check(s == es, d ? "R7 exact sum" : "R6 doubled sum", s, es);
      check(n == (d ? 126 : 63), d ? "R7 length" : "R6 length", n, d ? 126 : 63);
      check(dw == 0, "R8 done single cycle", dw, 0);
    end

    // R4: literal expectations under the counter source
    run(35, 21, 1'b0, 1'b0, 1'b0, s, o, n, m, dw);
    check(s == 56, "R4 35+21 exact", s, 56);
    run(30, 21, 1'b0, 1'b0, 1'b0, s, o, n, m, dw);
    check(s == 50, "R4 30+21 off by one", s, 50);
    // R7: exact double-length results, source ignored
    run(15, 8, 1'b1, 1'b1, 1'b0, s, o, n, m, dw);
    check(s == 23 && o == 23, "R7 15+8", s, 23);
    run(63, 63, 1'b0, 1'b1, 1'b0, s, o, n, m, dw);
    check(s == 126, "R7 63+63 maximum", s, 126);
    // R10: zero operands in every mode
    for (int k = 0; k < 3; k++) begin
      run(0, 0, k == 1, k == 2, 1'b0, s, o, n, m, dw);
      check(s == 0 && o == 0, "R10 zero sum", s, 0);
    end
    // R9: stray start mid-run is ignored
    run(35, 21, 1'b0, 1'b0, 1'b1, s, o, n, m, dw);
    check(s == 56 && n == 63 && m == 0, "R9 stray start", s, 56);
    // R8: result holds after done until the next start
    repeat (6) @(negedge clk);
    check(int'(sum_out) == 56 && done === 1'b0, "R8 hold", int'(sum_out), 56);
    check(bit_vld === 1'b0 && bit_out === 1'b0, "R8 idle stream",
          int'(bit_vld), 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule